// File: doc/BRIEF.md
# Exclusive Partitioned Victim Cache

This block is the shared last-level cache controller of a small multi-core cluster. It keeps no line that a core brought in from memory by itself. It only fills from lines that the cores' private caches throw out. A core sends an eviction, and the line is stored here as a victim. A later refill from any core that hits here returns the line and, by default, removes it, so a line lives either in a private cache or here and not in both places. A refill that misses becomes a read to external memory. The returned data goes to the core and is not stored here.

The ways of every set are split into four contiguous groups of four ways. Each core carries a small scheme ID, and a configuration field states which groups each scheme may allocate into, so cores can be kept out of each other's share of the cache. A no-allocate mode sends incoming evictions straight to memory instead of storing them, and a second control bit overrides that mode. An inclusive-refill flag covers the case of a line shared by a coherent read: the line is then kept here as well. Displaced dirty lines are written back to memory. Clean ones are dropped.

Top module: `vcache_top`

## Requirements
- R1: While rst_n is low at a clock edge, every line becomes invalid and every set's replacement pointer returns to way 0. After reset, req_ready is 1 and rsp_valid, mem_wr_valid and mem_rd_valid are 0.
- R2: An eviction that misses, outside no-allocate operation, stores tag, data and dirty flag in set req_addr[SET_W-1:0], using the lowest-numbered invalid way the core may use. It causes no memory traffic.
- R3: Way w belongs to group w/4. Core c uses scheme cfg_core_sid[c*2 +: 2]. Scheme s may allocate only into the groups whose bit is set in cfg_sid_grp[s*4 +: 4]. An allocation never writes or displaces a line in any other way.
- R4: When every permitted way of the set is valid, the victim is the first permitted way at or after the set's round-robin pointer, counted circularly. Every allocation sets the pointer to (chosen way + 1) mod 16. A dirty victim is written to memory at address {tag, set} one cycle after the request. A clean victim is dropped.
- R5: A refill that hits, with req_incl = 0, returns rsp_valid one cycle later with rsp_hit = 1, the line's data, its dirty flag and the requesting core's ID. The line is invalidated.
- R6: A refill that misses raises mem_rd_valid with the address one cycle later. req_ready stays 0 until mem_rdata_valid arrives. In the cycle after that, the response carries rsp_hit = 0, mem_rdata and rsp_dirty = 0. Nothing is allocated.
- R7: A refill that hits with req_incl = 1 leaves the line valid and unchanged, and returns it with rsp_dirty = 0.
- R8: An eviction that hits an existing line updates it in place (new data, dirty = old OR new). It causes no allocation and no memory traffic, whatever the mode.
- R9: With cfg_noalloc = 1 and cfg_noalloc_defeat = 0, an eviction that misses is not stored. If it is dirty, its address and data go out on the memory write port one cycle later. If it is clean, nothing happens.
- R10: cfg_noalloc_defeat = 1 cancels cfg_noalloc, so evictions that miss allocate as in R2 and R4.
- R11: An eviction miss from a core whose scheme has no permitted group is handled as in R9.
- R12: A request is taken when req_valid and req_ready are both 1. mem_rdata_valid is ignored while no memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_core_sid | input | CORES*SID_W | Scheme ID per core, core c at bits c*SID_W |
| cfg_sid_grp | input | (2**SID_W)*GROUPS | Group permission mask per scheme |
| cfg_noalloc | input | 1 | No-allocate mode request |
| cfg_noalloc_defeat | input | 1 | Forces no-allocate mode off |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 = eviction, 1 = refill |
| req_core | input | CORE_W | Requesting core ID |
| req_addr | input | ADDR_W | Line address; low SET_W bits select the set |
| req_data | input | DATA_W | Eviction data |
| req_dirty | input | 1 | Eviction line is dirty |
| req_incl | input | 1 | Refill keeps an inclusive copy here |
| rsp_valid | output | 1 | Refill response valid |
| rsp_hit | output | 1 | Response came from this cache |
| rsp_core | output | CORE_W | Core the response is for |
| rsp_data | output | DATA_W | Refill data |
| rsp_dirty | output | 1 | Dirty ownership passes to the core |
| mem_wr_valid | output | 1 | Memory write (write-back or bypass) |
| mem_wr_addr | output | ADDR_W | Memory write line address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read line address |
| mem_rdata_valid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the block with its defaults: 16 sets, a 16-bit line address, 32-bit line data and four cores. Each set then holds 16 ways, so a handful of tags per set fills a scheme's share of the set and pushes the round-robin victim choice through wrap-around. A permission layout of twelve ways for one scheme, four for another and none for a third makes isolation between partitions and the empty-partition bypass visible in the same set. A randomized phase concentrates traffic on four sets and reconfigures schemes and modes while the cache holds data. This exercises in-place updates, inclusive keeps and dirty write-backs across partition changes.

// File: rtl/vc_pkg.sv
// Shared types of the victim cache: request opcode and controller state.
package vc_pkg;
    typedef enum logic {
        OP_EVICT  = 1'b0,
        OP_REFILL = 1'b1
    } vc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } vc_state_e;
endpackage

// File: rtl/vc_part_mask.sv
// Turns a core ID into the mask of ways that core may allocate into.
// Assumes ways are split into GROUPS equal contiguous groups and that
// configuration inputs are stable while a request is taken.
module vc_part_mask #(
    parameter int CORES  = 4,
    parameter int SID_W  = 2,
    parameter int GROUPS = 4,
    parameter int WAYS   = 16,
    localparam int CORE_W   = (CORES > 1) ? $clog2(CORES) : 1,
    localparam int SCHEMES  = 1 << SID_W,
    localparam int GRP_WAYS = WAYS / GROUPS
) (
    input  logic [CORE_W-1:0]         core_id,
    input  logic [CORES*SID_W-1:0]    core_sid,
    input  logic [SCHEMES*GROUPS-1:0] sid_grp,
    output logic [WAYS-1:0]           allow_ways
);
    logic [SID_W-1:0]  sid;
    logic [GROUPS-1:0] grp;

    // Pick the scheme ID of the requesting core.
    always_comb begin
        sid = '0;
        for (int c = 0; c < CORES; c++) begin
            if (core_id == c[CORE_W-1:0]) sid = core_sid[c*SID_W +: SID_W];
        end
    end

    // Pick the group permission mask of that scheme.
    always_comb begin
        grp = '0;
        for (int s = 0; s < SCHEMES; s++) begin
            if (sid == s[SID_W-1:0]) grp = sid_grp[s*GROUPS +: GROUPS];
        end
    end

    // Each way inherits the permission of its group.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign allow_ways[w] = grp[w / GRP_WAYS];
    end
endmodule

// File: rtl/vc_victim_pick.sv
// Chooses the way for a new allocation inside the permitted ways:
// lowest invalid permitted way first, else the first permitted way at or
// after the round-robin pointer. Assumes WAYS is a power of two.
module vc_victim_pick #(
    parameter int WAYS = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld,
    input  logic [WAYS-1:0]  allow,
    input  logic [WAY_W-1:0] ptr,
    output logic             found,
    output logic [WAY_W-1:0] way,
    output logic [WAY_W-1:0] ptr_nxt
);
    logic             inv_found;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] rr_way;

    // Lowest-numbered free permitted way (scan downward so lowest wins).
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (allow[w] && !vld[w]) begin
                inv_found = 1'b1;
                inv_way   = w[WAY_W-1:0];
            end
        end
    end

    // First permitted way at or after the pointer, circular.
    always_comb begin
        rr_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (allow[(int'(ptr) + i) % WAYS]) rr_way = WAY_W'((int'(ptr) + i) % WAYS);
        end
    end

    // Final choice and the pointer value that follows it.
    always_comb begin
        found   = |allow;
        way     = inv_found ? inv_way : rr_way;
        ptr_nxt = way + WAY_W'(1);
    end
endmodule

// File: rtl/vc_line_store.sv
// Tag, data, valid, dirty and round-robin pointer storage of all sets.
// Reads the set addressed by lk_set combinationally; one line write and
// one pointer write per cycle, both to that same set.
module vc_line_store #(
    parameter int SETS   = 16,
    parameter int WAYS   = 16,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SET_W-1:0]              lk_set,
    output logic [WAYS-1:0]               set_vld,
    output logic [WAYS-1:0]               set_dty,
    output logic [WAYS-1:0][TAG_W-1:0]    set_tag,
    output logic [WAYS-1:0][DATA_W-1:0]   set_dat,
    output logic [WAY_W-1:0]              set_ptr,
    input  logic                          wr_en,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic                          wr_vld,
    input  logic                          wr_dty,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_dat,
    input  logic                          ptr_en,
    input  logic [WAY_W-1:0]              ptr_val
);
    logic [WAYS-1:0]             vld_q [SETS];
    logic [WAYS-1:0]             dty_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
    logic [WAYS-1:0][DATA_W-1:0] dat_q [SETS];
    logic [WAY_W-1:0]            ptr_q [SETS];

    // Read port for the looked-up set.
    always_comb begin
        set_vld = vld_q[lk_set];
        set_dty = dty_q[lk_set];
        set_tag = tag_q[lk_set];
        set_dat = dat_q[lk_set];
        set_ptr = ptr_q[lk_set];
    end

    // State bits with reset: valid, dirty and replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                dty_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else begin
            if (wr_en) begin
                vld_q[lk_set][wr_way] <= wr_vld;
                dty_q[lk_set][wr_way] <= wr_dty;
            end
            if (ptr_en) ptr_q[lk_set] <= ptr_val;
        end
    end

    // Payload bits without reset: tag and data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[lk_set][wr_way] <= wr_tag;
            dat_q[lk_set][wr_way] <= wr_dat;
        end
    end
endmodule

// File: rtl/vcache_top.sv
// Exclusive victim cache controller with per-scheme way partitioning.
// Evictions allocate (or bypass to memory), refills hit and leave, or miss
// and read memory without allocating. One request at a time; memory writes
// are assumed always accepted; configuration is quasi-static.
module vcache_top #(
    parameter int SETS   = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CORES  = 4,
    parameter int SID_W  = 2,
    parameter int WAYS   = 16,
    parameter int GROUPS = 4,
    localparam int SET_W   = $clog2(SETS),
    localparam int TAG_W   = ADDR_W - SET_W,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int CORE_W  = (CORES > 1) ? $clog2(CORES) : 1,
    localparam int SCHEMES = 1 << SID_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CORES*SID_W-1:0]    cfg_core_sid,
    input  logic [SCHEMES*GROUPS-1:0] cfg_sid_grp,
    input  logic                      cfg_noalloc,
    input  logic                      cfg_noalloc_defeat,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_op,
    input  logic [CORE_W-1:0]         req_core,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_data,
    input  logic                      req_dirty,
    input  logic                      req_incl,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic [CORE_W-1:0]         rsp_core,
    output logic [DATA_W-1:0]         rsp_data,
    output logic                      rsp_dirty,
    output logic                      mem_wr_valid,
    output logic [ADDR_W-1:0]         mem_wr_addr,
    output logic [DATA_W-1:0]         mem_wr_data,
    output logic                      mem_rd_valid,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    input  logic                      mem_rdata_valid,
    input  logic [DATA_W-1:0]         mem_rdata
);
    import vc_pkg::*;

    vc_state_e                  state_q;
    logic [CORE_W-1:0]          core_q;
    logic [SET_W-1:0]           lk_set;
    logic [TAG_W-1:0]           lk_tag;
    logic [WAYS-1:0]            set_vld, set_dty, hit_vec, allow;
    logic [WAYS-1:0][TAG_W-1:0] set_tag;
    logic [WAYS-1:0][DATA_W-1:0] set_dat;
    logic [WAY_W-1:0]           set_ptr, hit_way, pick_way, pick_ptr;
    logic                       pick_found, hit, acc, is_ev, bypass;
    logic                       st_we, st_vld, st_dty, ptr_en;
    logic [WAY_W-1:0]           st_way;
    logic [TAG_W-1:0]           st_tag;
    logic [DATA_W-1:0]          st_dat;
    logic                       wr_n, rd_n, rsp_n, rsp_hit_n, rsp_dty_n;
    logic [ADDR_W-1:0]          wr_addr_n;
    logic [DATA_W-1:0]          wr_dat_n, rsp_dat_n;

    assign lk_set    = req_addr[SET_W-1:0];
    assign lk_tag    = req_addr[ADDR_W-1:SET_W];
    assign req_ready = (state_q == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign is_ev     = (vc_op_e'(req_op) == OP_EVICT);
    assign bypass    = (cfg_noalloc && !cfg_noalloc_defeat) || !pick_found;

    vc_part_mask #(.CORES(CORES), .SID_W(SID_W), .GROUPS(GROUPS), .WAYS(WAYS)) u_part (
        .core_id(req_core), .core_sid(cfg_core_sid), .sid_grp(cfg_sid_grp), .allow_ways(allow)
    );

    vc_line_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .lk_set(lk_set),
        .set_vld(set_vld), .set_dty(set_dty), .set_tag(set_tag), .set_dat(set_dat), .set_ptr(set_ptr),
        .wr_en(st_we), .wr_way(st_way), .wr_vld(st_vld), .wr_dty(st_dty), .wr_tag(st_tag), .wr_dat(st_dat),
        .ptr_en(ptr_en), .ptr_val(pick_ptr)
    );

    vc_victim_pick #(.WAYS(WAYS)) u_pick (
        .vld(set_vld), .allow(allow), .ptr(set_ptr),
        .found(pick_found), .way(pick_way), .ptr_nxt(pick_ptr)
    );

    // Tag compare across all ways of the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = set_vld[w] && (set_tag[w] == lk_tag);
    end

    // Encode the hitting way (at most one way matches).
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = w[WAY_W-1:0];
        end
        hit = |hit_vec;
    end

    // Decide store update, memory traffic and response for this cycle.
    always_comb begin
        st_we = 1'b0;  st_way = hit_way; st_vld = 1'b1; st_dty = 1'b0;
        st_tag = lk_tag; st_dat = req_data; ptr_en = 1'b0;
        wr_n = 1'b0; wr_addr_n = req_addr; wr_dat_n = req_data; rd_n = 1'b0;
        rsp_n = 1'b0; rsp_hit_n = 1'b0; rsp_dat_n = mem_rdata; rsp_dty_n = 1'b0;
        if (acc && is_ev) begin
            if (hit) begin
                st_we  = 1'b1;
                st_dty = set_dty[hit_way] | req_dirty;
            end else if (bypass) begin
                wr_n = req_dirty;
            end else begin
                st_we  = 1'b1;
                st_way = pick_way;
                st_dty = req_dirty;
                ptr_en = 1'b1;
                wr_n   = set_vld[pick_way] && set_dty[pick_way];
                wr_addr_n = {set_tag[pick_way], lk_set};
                wr_dat_n  = set_dat[pick_way];
            end
        end else if (acc) begin
            if (hit) begin
                rsp_n     = 1'b1;
                rsp_hit_n = 1'b1;
                rsp_dat_n = set_dat[hit_way];
                rsp_dty_n = set_dty[hit_way] && !req_incl;
                st_we     = !req_incl;
                st_vld    = 1'b0;
                st_tag    = set_tag[hit_way];
                st_dat    = set_dat[hit_way];
            end else begin
                rd_n = 1'b1;
            end
        end else if (state_q == ST_WAIT && mem_rdata_valid) begin
            rsp_n = 1'b1;
        end
    end

    // Controller state: wait for memory after a refill miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            core_q  <= '0;
        end else begin
            if (acc) core_q <= req_core;
            if (rd_n) state_q <= ST_WAIT;
            else if (state_q == ST_WAIT && mem_rdata_valid) state_q <= ST_IDLE;
        end
    end

    // Registered outputs towards cores and memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_core <= '0; rsp_data <= '0; rsp_dirty <= 1'b0;
            mem_wr_valid <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
            mem_rd_valid <= 1'b0; mem_rd_addr <= '0;
        end else begin
            rsp_valid    <= rsp_n;
            rsp_hit      <= rsp_hit_n;
            rsp_core     <= (state_q == ST_WAIT) ? core_q : req_core;
            rsp_data     <= rsp_dat_n;
            rsp_dirty    <= rsp_dty_n;
            mem_wr_valid <= wr_n;
            mem_wr_addr  <= wr_addr_n;
            mem_wr_data  <= wr_dat_n;
            mem_rd_valid <= rd_n;
            mem_rd_addr  <= req_addr;
        end
    end

    AST_ALLOC_IN_PART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && ptr_en) |-> allow[st_way]); // R3
    AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !is_ev && hit) |=> (rsp_valid && rsp_hit)); // R5
    AST_RD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready); // R6
    AST_RSP_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, mem_rd_valid})); // R6
    AST_EVHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_ev && hit) |=> (!mem_wr_valid && !mem_rd_valid)); // R8
    AST_CLEAN_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && is_ev && !hit && bypass && !req_dirty) |=> !mem_wr_valid); // R9
    AST_IDLE_RDATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> !rsp_valid); // R12
endmodule

// File: tb/vcache_top_bench.sv
`timescale 1ns/1ps
module vcache_top_bench;
    localparam int SETS = 16, ADDR_W = 16, DATA_W = 32, CORES = 4, WAYS = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  cfg_core_sid;
    logic [15:0] cfg_sid_grp;
    logic cfg_noalloc = 1'b0, cfg_noalloc_defeat = 1'b0;
    logic req_valid = 1'b0, req_ready, req_op = 1'b0, req_dirty = 1'b0, req_incl = 1'b0;
    logic [1:0] req_core = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic rsp_valid, rsp_hit, rsp_dirty, mem_wr_valid, mem_rd_valid;
    logic [1:0] rsp_core;
    logic [DATA_W-1:0] rsp_data, mem_wr_data;
    logic [ADDR_W-1:0] mem_wr_addr, mem_rd_addr;
    logic mem_rdata_valid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    vcache_top u_vcache_top (
        .clk(clk), .rst_n(rst_n), .cfg_core_sid(cfg_core_sid), .cfg_sid_grp(cfg_sid_grp),
        .cfg_noalloc(cfg_noalloc), .cfg_noalloc_defeat(cfg_noalloc_defeat),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_core(req_core),
        .req_addr(req_addr), .req_data(req_data), .req_dirty(req_dirty), .req_incl(req_incl),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_core(rsp_core), .rsp_data(rsp_data),
        .rsp_dirty(rsp_dirty), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    // Reference model state
    bit m_vld [SETS][WAYS];
    bit m_dty [SETS][WAYS];
    int m_tag [SETS][WAYS];
    logic [31:0] m_dat [SETS][WAYS];
    int m_ptr [SETS];
    logic [31:0] mem_img [int];
    int sid_of [CORES];
    int grp_of [4];
    // Expected outputs for the next compare
    bit e_ready = 1, e_rsp = 0, e_hit = 0, e_rdty = 0, e_wr = 0, e_rd = 0;
    int e_rcore = 0, e_waddr = 0, e_raddr = 0;
    logic [31:0] e_rdat = '0, e_wdat = '0;
    string e_tag = "R1";

    function automatic logic [31:0] mem_val(int a);
        if (mem_img.exists(a)) return mem_img[a];
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", e_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(req_ready == e_ready, "req_ready", 64'(req_ready), 64'(e_ready));
        chk(rsp_valid == e_rsp, "rsp_valid", 64'(rsp_valid), 64'(e_rsp));
        if (e_rsp && rsp_valid) begin
            chk(rsp_hit == e_hit, "rsp_hit", 64'(rsp_hit), 64'(e_hit));
            chk(rsp_data == e_rdat, "rsp_data", 64'(rsp_data), 64'(e_rdat));
            chk(rsp_dirty == e_rdty, "rsp_dirty", 64'(rsp_dirty), 64'(e_rdty));
            chk(int'(rsp_core) == e_rcore, "rsp_core", 64'(rsp_core), 64'(e_rcore));
        end
        chk(mem_wr_valid == e_wr, "mem_wr_valid", 64'(mem_wr_valid), 64'(e_wr));
        if (e_wr && mem_wr_valid) begin
            chk(int'(mem_wr_addr) == e_waddr, "mem_wr_addr", 64'(mem_wr_addr), 64'(e_waddr));
            chk(mem_wr_data == e_wdat, "mem_wr_data", 64'(mem_wr_data), 64'(e_wdat));
        end
        chk(mem_rd_valid == e_rd, "mem_rd_valid", 64'(mem_rd_valid), 64'(e_rd));
        if (e_rd && mem_rd_valid)
            chk(int'(mem_rd_addr) == e_raddr, "mem_rd_addr", 64'(mem_rd_addr), 64'(e_raddr));
        e_rsp = 0; e_wr = 0; e_rd = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_cfg();
        for (int c = 0; c < CORES; c++) cfg_core_sid[c*2 +: 2] = 2'(sid_of[c]);
        for (int s = 0; s < 4; s++) cfg_sid_grp[s*4 +: 4] = 4'(grp_of[s]);
    endtask

    // Behavioural model of one request; sets expectations and updates state.
    task automatic model_req(bit refill, int core, int addr, logic [31:0] data, bit dirty,
                             bit incl, output bit miss, output string tg);
        int s, t, hw, grp, pw, ww;
        s = addr % SETS; t = addr / SETS; hw = -1; pw = -1;
        grp = grp_of[sid_of[core]];
        miss = 0; e_ready = 1;
        for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) hw = w;
        if (!refill) begin
            if (hw >= 0) begin
                m_dat[s][hw] = data; m_dty[s][hw] = m_dty[s][hw] | dirty; tg = "R8";
            end else if ((cfg_noalloc && !cfg_noalloc_defeat) || grp == 0) begin
                tg = (grp == 0) ? "R11" : "R9";
                if (dirty) begin e_wr = 1; e_waddr = addr; e_wdat = data; mem_img[addr] = data; end
            end else begin
                for (int w = WAYS - 1; w >= 0; w--) if (((grp >> (w / 4)) & 1) == 1 && !m_vld[s][w]) pw = w;
                if (pw < 0) begin
                    for (int i = WAYS - 1; i >= 0; i--) begin
                        ww = (m_ptr[s] + i) % WAYS;
                        if (((grp >> (ww / 4)) & 1) == 1) pw = ww;
                    end
                end
                tg = m_vld[s][pw] ? "R4" : "R2";
                if (m_vld[s][pw] && m_dty[s][pw]) begin
                    e_wr = 1; e_waddr = m_tag[s][pw] * SETS + s; e_wdat = m_dat[s][pw];
                    mem_img[e_waddr] = e_wdat;
                end
                m_vld[s][pw] = 1; m_dty[s][pw] = dirty; m_tag[s][pw] = t; m_dat[s][pw] = data;
                m_ptr[s] = (pw + 1) % WAYS;
            end
        end else if (hw >= 0) begin
            e_rsp = 1; e_hit = 1; e_rdat = m_dat[s][hw]; e_rcore = core;
            e_rdty = incl ? 0 : m_dty[s][hw];
            if (!incl) m_vld[s][hw] = 0;
            tg = incl ? "R7" : "R5";
        end else begin
            miss = 1; e_rd = 1; e_raddr = addr; e_ready = 0; tg = "R6";
        end
    endtask

    task automatic do_req(bit refill, int core, int addr, logic [31:0] data, bit dirty,
                          bit incl, string tag);
        bit miss;
        string tg;
        req_op = refill; req_core = 2'(core); req_addr = ADDR_W'(addr);
        req_data = data; req_dirty = dirty; req_incl = incl; req_valid = 1'b1;
        model_req(refill, core, addr, data, dirty, incl, miss, tg);
        e_tag = (tag == "") ? tg : tag;
        step();
        req_valid = 1'b0;
        if (miss) begin
            step();
            step();
            mem_rdata_valid = 1'b1; mem_rdata = mem_val(addr);
            e_rsp = 1; e_hit = 0; e_rdat = mem_val(addr); e_rdty = 0; e_rcore = core; e_ready = 1;
            step();
            mem_rdata_valid = 1'b0;
        end
    endtask

    task automatic evict(int core, int addr, bit dirty, logic [31:0] data, string tag);
        do_req(0, core, addr, dirty ? data : mem_val(addr), dirty, 0, tag);
    endtask

    task automatic refill(int core, int addr, bit incl, string tag);
        do_req(1, core, addr, '0, 0, incl, tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        sid_of = '{0, 1, 0, 3};
        grp_of = '{4'b0111, 4'b1000, 4'b1111, 4'b0000};
        set_cfg();
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 0; m_dty[s][w] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_tag = "R1";
        compare();                       // R1: reset state
        step();

        // R2: fill core 0's twelve ways of set 0 with dirty lines
        for (int i = 0; i < 12; i++) evict(0, i * SETS, 1, 32'h100 + 32'(i), "R2");
        // R4: thirteenth line displaces way 0 (dirty write-back of address 0)
        evict(0, 12 * SETS, 1, 32'h10C, "R4");
        // R3: core 1 confined to ways 12..15; core 0 lines survive
        for (int i = 0; i < 5; i++) evict(1, (20 + i) * SETS, 1, 32'h200 + 32'(i), "R3");
        for (int i = 1; i < 12; i++) refill(0, i * SETS, 1, "R3");
        // R4: clean victim dropped silently in set 1
        for (int i = 0; i < 13; i++) evict(0, i * SETS + 1, 0, '0, "R4");
        // R5 then R6: exclusive hit removes the line, second refill misses
        refill(2, 12 * SETS, 0, "R5");
        refill(2, 12 * SETS, 0, "R6");
        refill(1, 40 * SETS + 7, 0, "R6");
        refill(1, 40 * SETS + 7, 0, "R6");
        // R7: inclusive keep, twice, then exclusive take
        evict(0, 5 * SETS + 2, 1, 32'hABCD, "R7");
        refill(1, 5 * SETS + 2, 1, "R7");
        refill(3, 5 * SETS + 2, 1, "R7");
        refill(0, 5 * SETS + 2, 0, "R7");
        // R8: in-place update, dirty OR
        evict(0, 7 * SETS + 3, 0, '0, "R8");
        evict(0, 7 * SETS + 3, 1, 32'h7777, "R8");
        refill(0, 7 * SETS + 3, 0, "R8");
        // R9: no-allocate mode
        cfg_noalloc = 1'b1;
        evict(0, 3 * SETS + 4, 1, 32'h4444, "R9");
        evict(0, 4 * SETS + 4, 0, '0, "R9");
        refill(0, 3 * SETS + 4, 0, "R9");
        evict(0, 9 * SETS + 1, 1, 32'h9191, "R8");
        // R10: defeat bit forces allocation
        cfg_noalloc_defeat = 1'b1;
        evict(0, 6 * SETS + 5, 1, 32'h6565, "R10");
        refill(0, 6 * SETS + 5, 0, "R10");
        cfg_noalloc = 1'b0; cfg_noalloc_defeat = 1'b0;
        // R11: empty partition bypasses
        evict(3, 2 * SETS + 6, 1, 32'h2626, "R11");
        evict(3, 3 * SETS + 6, 0, '0, "R11");
        refill(3, 2 * SETS + 6, 0, "R11");
        // R12: stray memory data while idle produces nothing
        e_tag = "R12";
        mem_rdata_valid = 1'b1; mem_rdata = 32'hDEAD;
        step();
        mem_rdata_valid = 1'b0;
        step();

        // Randomized traffic with occasional reconfiguration
        for (int n = 0; n < 600; n++) begin
            int core, addr, kind;
            core = $urandom_range(0, 3);
            addr = $urandom_range(0, 15) * SETS + $urandom_range(0, 3);
            kind = $urandom_range(0, 9);
            if (kind == 0) begin
                for (int c = 0; c < CORES; c++) sid_of[c] = $urandom_range(0, 3);
                for (int s = 0; s < 4; s++) grp_of[s] = $urandom_range(0, 15);
                cfg_noalloc = ($urandom_range(0, 3) == 0);
                cfg_noalloc_defeat = ($urandom_range(0, 1) == 0);
                set_cfg();
            end else if (kind < 6) begin
                evict(core, addr, $urandom_range(0, 1) == 1, $urandom(), "");
            end else begin
                refill(core, addr, $urandom_range(0, 4) == 0, "");
            end
        end
        finish_run();
    end
endmodule